// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block scans a key matrix of up to sixteen rows by eight columns. It drives one row at a time and reads eight active-low column lines at the end of each row's dwell time. In decoder mode the four row pins carry the row number as a binary code for an external 4-to-16 decoder. In direct mode the same four pins drive a 4×8 matrix directly, with one line pulled low at a time.

The block collects one full frame of samples (every row once) and compares it with the frame before. A new key map is accepted only when the same frame has been seen for a programmable number of consecutive frames. From the accepted map the block reports the number of pressed keys and the codes of the lowest two, each code being `row*8 + column`. It pulses an interrupt when the reported count becomes one or two. It pulls an active-low reset output when exactly three keys are held and they match a programmed chord. It raises a wake-up request while the system signals idle or power-down and any key is held.

Top module: `keyscan_top`

## Requirements
- R1: With `dec_mode`=1, `row_out` carries the row number as a 4-bit binary code and visits all sixteen values 0..15 in turn. Each row is held for `row_dwell` scan ticks (0 counts as 1), and one scan tick is PRESCALE clocks.
- R2: With `dec_mode`=0, exactly one bit of `row_out` is low at any time, the low bit being the row number 0..3, and every one of the four bits takes its turn.
- R3: A column bit at 0 while its row is driven means the key at that row and column is pressed. Its key code is `{row[3:0], col[2:0]}`, i.e. row*8+column, and in direct mode only rows 0..3 exist.
- R4: A change of the key map is accepted only after the same frame has been sampled in `deb_frames` consecutive frames (0 counts as 1). A press that lasts about one frame while `deb_frames`=4 causes no report and no interrupt.
- R5: After each accepted map holding at most three keys, `key_count` gives the number of keys (0..3). `key_first` gives the lowest key code, or 0 if there is none, and `key_second` the next higher code, or 0 if there is none.
- R6: `key_irq` is a one-cycle pulse, given when a new report has count 1 or 2 and that count differs from the count reported before.
- R7: `rst_out_n` is low while `chord_en`=1 and the accepted map holds exactly three keys, those three being `chord_a`, `chord_b` and `chord_c` (three distinct codes). Otherwise it is high.
- R8: An accepted map with more than three keys leaves `key_count`, `key_first` and `key_second` unchanged, gives no interrupt and keeps `rst_out_n` high.
- R9: `wake_req` is high while `sleep_req` is high and the accepted map holds at least one key, and low otherwise.
- R10: After reset, `key_count`=0, `key_first`=0, `key_second`=0, `key_irq`=0, `rst_out_n`=1 and `wake_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous reset, active low, released synchronously inside |
| scan_en | input | 1 | Enables the scan tick and the row sequencing |
| dec_mode | input | 1 | 1: encoded rows for a 16-row decoder; 0: four direct row lines |
| row_dwell | input | DWELL_W | Scan ticks per row |
| deb_frames | input | DEB_W | Consecutive identical frames needed to accept a change |
| col_n | input | 8 | Column inputs, active low |
| chord_en | input | 1 | Enables the three-key reset chord |
| chord_a | input | 7 | First chord key code |
| chord_b | input | 7 | Second chord key code |
| chord_c | input | 7 | Third chord key code |
| sleep_req | input | 1 | System is idle or powered down |
| row_out | output | 4 | Row drive: binary code or one-low lines |
| key_count | output | 3 | Reported number of pressed keys |
| key_first | output | 7 | Lowest reported key code |
| key_second | output | 7 | Second reported key code |
| key_irq | output | 1 | Interrupt pulse on report of one or two keys |
| rst_out_n | output | 1 | Chord reset output, active low |
| wake_req | output | 1 | Wake-up request |

## Verification
The hardest case to reach from the ports is a press that is too short to be accepted while still spanning whole sampled frames. The bench keeps a key closed for exactly one frame length with the debounce count at four. It then checks that neither a report nor an interrupt appears. The column inputs come from a bench model of the matrix that decodes `row_out` in both modes. Random key sets of zero to five keys, some of them the reset chord, are applied after directed cases. These sets walk the report through the overflow hold and back.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  localparam int COLS        = 8;
  localparam int MAX_ROWS    = 16;
  localparam int DIRECT_ROWS = 4;
  localparam int ROW_W       = $clog2(MAX_ROWS);
  localparam int COL_W       = $clog2(COLS);
  localparam int CODE_W      = ROW_W + COL_W;
  localparam int KEYS        = MAX_ROWS * COLS;
  localparam int CNT_W       = 3;

  typedef logic [CODE_W-1:0] key_code_t;
  typedef logic [KEYS-1:0]   key_map_t;
endpackage

// File: rtl/keyscan_timer.sv
module keyscan_timer
  import keyscan_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int DWELL_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic               dec_mode,
  input  logic [DWELL_W-1:0] row_dwell,
  output logic [ROW_W-1:0]   row_idx,
  output logic               sample_stb,
  output logic               frame_stb
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]   pre_cnt, pre_cnt_nx;
  logic [DWELL_W-1:0] dw_cnt, dw_cnt_nx;
  logic [ROW_W-1:0]   row_nx;
  logic [DWELL_W-1:0] dwell_eff;
  logic [ROW_W-1:0]   last_row;
  logic               tick, dwell_done;

  always_comb begin
    dwell_eff  = (row_dwell == '0) ? DWELL_W'(1) : row_dwell;
    last_row   = dec_mode ? ROW_W'(MAX_ROWS - 1) : ROW_W'(DIRECT_ROWS - 1);
    tick       = scan_en && (pre_cnt == PRE_LAST);
    dwell_done = ({1'b0, dw_cnt} + 1'b1) >= {1'b0, dwell_eff};
    sample_stb = tick && dwell_done;
    frame_stb  = sample_stb && (row_idx >= last_row);

    pre_cnt_nx = pre_cnt;
    dw_cnt_nx  = dw_cnt;
    row_nx     = row_idx;
    if (scan_en) begin
      pre_cnt_nx = (pre_cnt == PRE_LAST) ? '0 : pre_cnt + 1'b1;
    end
    if (tick) begin
      dw_cnt_nx = dwell_done ? '0 : dw_cnt + 1'b1;
    end
    if (sample_stb) begin
      row_nx = (row_idx >= last_row) ? '0 : row_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      dw_cnt  <= '0;
      row_idx <= '0;
    end else begin
      pre_cnt <= pre_cnt_nx;
      dw_cnt  <= dw_cnt_nx;
      row_idx <= row_nx;
    end
  end

  // a row advance only happens on a sample strobe
  AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (row_idx != $past(row_idx)) |-> $past(sample_stb)) else $error("row moved without sample"); // R1
endmodule

// File: rtl/keyscan_rowdrv.sv
module keyscan_rowdrv
  import keyscan_pkg::*;
#(
  parameter int ROW_PINS = 4
) (
  input  logic                dec_mode,
  input  logic [ROW_W-1:0]    row_idx,
  output logic [ROW_PINS-1:0] row_out
);
  localparam int SEL_W = $clog2(ROW_PINS);

  logic [ROW_PINS-1:0] direct_n;

  genvar g;
  generate
    for (g = 0; g < ROW_PINS; g++) begin : g_line
      assign direct_n[g] = (row_idx[SEL_W-1:0] != SEL_W'(g));
    end
  endgenerate

  assign row_out = dec_mode ? ROW_PINS'(row_idx) : direct_n;
endmodule

// File: rtl/keyscan_debounce.sv
module keyscan_debounce
  import keyscan_pkg::*;
#(
  parameter int DEB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_mode,
  input  logic [ROW_W-1:0] row_idx,
  input  logic             sample_stb,
  input  logic             frame_stb,
  input  logic [COLS-1:0]  col_n,
  input  logic [DEB_W-1:0] deb_frames,
  output key_map_t         deb_map,
  output logic             upd
);
  key_map_t         cur_snap, cur_snap_nx;
  key_map_t         last_frame, last_frame_nx;
  key_map_t         deb_map_nx;
  key_map_t         frame_view;
  logic [DEB_W-1:0] run, run_nx, deb_eff;
  logic             upd_nx, same;

  always_comb begin
    frame_view = cur_snap;
    for (int r = 0; r < MAX_ROWS; r++) begin
      if (ROW_W'(r) == row_idx) frame_view[r*COLS +: COLS] = ~col_n;
      if (!dec_mode && (r >= DIRECT_ROWS)) frame_view[r*COLS +: COLS] = '0;
    end
  end

  always_comb begin
    deb_eff       = (deb_frames == '0) ? DEB_W'(1) : deb_frames;
    same          = (frame_view == last_frame);
    cur_snap_nx   = sample_stb ? frame_view : cur_snap;
    last_frame_nx = last_frame;
    run_nx        = run;
    deb_map_nx    = deb_map;
    upd_nx        = 1'b0;
    if (frame_stb) begin
      last_frame_nx = frame_view;
      if (!same)             run_nx = DEB_W'(1);
      else if (run != '1)    run_nx = run + 1'b1;
      if ((run_nx >= deb_eff) && (frame_view != deb_map)) begin
        deb_map_nx = frame_view;
        upd_nx     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_snap   <= '0;
      last_frame <= '0;
      run        <= '0;
      deb_map    <= '0;
      upd        <= 1'b0;
    end else begin
      cur_snap   <= cur_snap_nx;
      last_frame <= last_frame_nx;
      run        <= run_nx;
      deb_map    <= deb_map_nx;
      upd        <= upd_nx;
    end
  end

  AST_UPD_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> $past(frame_stb)) else $error("map update off frame end"); // R4
  AST_MAP_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> $stable(deb_map)) else $error("map changed silently"); // R4
endmodule

// File: rtl/keyscan_report.sv
module keyscan_report
  import keyscan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  key_map_t         deb_map,
  input  logic             upd,
  input  logic             chord_en,
  input  key_code_t        chord_a,
  input  key_code_t        chord_b,
  input  key_code_t        chord_c,
  input  logic             sleep_req,
  output logic [CNT_W-1:0] key_count,
  output key_code_t        key_first,
  output key_code_t        key_second,
  output logic             key_irq,
  output logic             rst_out_n,
  output logic             wake_req
);
  logic [CNT_W-1:0] cnt, count_nx;
  key_code_t        first, second, first_nx, second_nx;
  logic             new_report, irq_nx, chord_hit, wake_nx;

  always_comb begin
    cnt    = '0;
    first  = '0;
    second = '0;
    for (int i = 0; i < KEYS; i++) begin
      if (deb_map[i]) begin
        if (cnt == CNT_W'(0)) first  = CODE_W'(i);
        if (cnt == CNT_W'(1)) second = CODE_W'(i);
        if (cnt < CNT_W'(4))  cnt    = cnt + 1'b1;
      end
    end
  end

  always_comb begin
    new_report = upd && (cnt <= CNT_W'(3));
    count_nx   = new_report ? cnt    : key_count;
    first_nx   = new_report ? first  : key_first;
    second_nx  = new_report ? second : key_second;
    irq_nx     = new_report && ((cnt == CNT_W'(1)) || (cnt == CNT_W'(2)))
                 && (cnt != key_count);
    chord_hit  = chord_en && (cnt == CNT_W'(3)) &&
                 deb_map[chord_a] && deb_map[chord_b] && deb_map[chord_c];
    wake_nx    = sleep_req && (cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_count  <= '0;
      key_first  <= '0;
      key_second <= '0;
      key_irq    <= 1'b0;
      rst_out_n  <= 1'b1;
      wake_req   <= 1'b0;
    end else begin
      key_count  <= count_nx;
      key_first  <= first_nx;
      key_second <= second_nx;
      key_irq    <= irq_nx;
      rst_out_n  <= !chord_hit;
      wake_req   <= wake_nx;
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    key_count <= CNT_W'(3)) else $error("count above three"); // R8
  AST_KEY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (key_count >= CNT_W'(2)) |-> (key_second > key_first)) else $error("order"); // R5
  AST_IRQ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    key_irq |-> ((key_count == CNT_W'(1)) || (key_count == CNT_W'(2)))) else $error("irq count"); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    key_irq |=> !key_irq) else $error("irq longer than a cycle"); // R6
  AST_CHORD_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> (key_count == CNT_W'(3))) else $error("chord without three keys"); // R7
  AST_WAKE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(sleep_req)) else $error("wake while awake"); // R9
endmodule

// File: rtl/keyscan_top.sv
module keyscan_top
  import keyscan_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int DWELL_W  = 4,
  parameter int DEB_W    = 4,
  parameter int ROW_PINS = 4
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                scan_en,
  input  logic                dec_mode,
  input  logic [DWELL_W-1:0]  row_dwell,
  input  logic [DEB_W-1:0]    deb_frames,
  input  logic [COLS-1:0]     col_n,
  input  logic                chord_en,
  input  logic [CODE_W-1:0]   chord_a,
  input  logic [CODE_W-1:0]   chord_b,
  input  logic [CODE_W-1:0]   chord_c,
  input  logic                sleep_req,
  output logic [ROW_PINS-1:0] row_out,
  output logic [CNT_W-1:0]    key_count,
  output logic [CODE_W-1:0]   key_first,
  output logic [CODE_W-1:0]   key_second,
  output logic                key_irq,
  output logic                rst_out_n,
  output logic                wake_req
);
  logic [1:0]       rst_sync;
  logic             rst_n;
  logic [ROW_W-1:0] row_idx;
  logic             sample_stb, frame_stb, upd;
  key_map_t         deb_map;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  keyscan_timer #(.PRESCALE(PRESCALE), .DWELL_W(DWELL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .dec_mode(dec_mode),
    .row_dwell(row_dwell), .row_idx(row_idx), .sample_stb(sample_stb),
    .frame_stb(frame_stb));

  keyscan_rowdrv #(.ROW_PINS(ROW_PINS)) u_rowdrv (
    .dec_mode(dec_mode), .row_idx(row_idx), .row_out(row_out));

  keyscan_debounce #(.DEB_W(DEB_W)) u_deb (
    .clk(clk), .rst_n(rst_n), .dec_mode(dec_mode), .row_idx(row_idx),
    .sample_stb(sample_stb), .frame_stb(frame_stb), .col_n(col_n),
    .deb_frames(deb_frames), .deb_map(deb_map), .upd(upd));

  keyscan_report u_rep (
    .clk(clk), .rst_n(rst_n), .deb_map(deb_map), .upd(upd),
    .chord_en(chord_en), .chord_a(chord_a), .chord_b(chord_b), .chord_c(chord_c),
    .sleep_req(sleep_req), .key_count(key_count), .key_first(key_first),
    .key_second(key_second), .key_irq(key_irq), .rst_out_n(rst_out_n),
    .wake_req(wake_req));

  AST_DIRECT_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_mode |-> ($countones(~row_out) == 1)) else $error("direct rows"); // R2
endmodule

// File: tb/sim_keyscan_top.sv
module sim_keyscan_top;
  localparam int PRE   = 4;
  localparam int DWELL = 2;

  logic        clk = 1'b0;
  logic        arst_n, scan_en, dec_mode, chord_en, sleep_req;
  logic [3:0]  row_dwell, deb_frames;
  logic [7:0]  col_n;
  logic [6:0]  chord_a, chord_b, chord_c;
  logic [3:0]  row_out;
  logic [2:0]  key_count;
  logic [6:0]  key_first, key_second;
  logic        key_irq, rst_out_n, wake_req;

  logic [127:0] keys;
  int tests = 0, fails = 0, irq_seen = 0, cycles = 0;
  int rep_count = 0, rep_first = 0, rep_second = 0;

  always #10 clk = ~clk;

  keyscan_top u0 (
    .clk(clk), .arst_n(arst_n), .scan_en(scan_en), .dec_mode(dec_mode),
    .row_dwell(row_dwell), .deb_frames(deb_frames), .col_n(col_n),
    .chord_en(chord_en), .chord_a(chord_a), .chord_b(chord_b), .chord_c(chord_c),
    .sleep_req(sleep_req), .row_out(row_out), .key_count(key_count),
    .key_first(key_first), .key_second(key_second), .key_irq(key_irq),
    .rst_out_n(rst_out_n), .wake_req(wake_req));

  // matrix model: closed key pulls its column low while its row is driven (R3)
  always_comb begin
    int r;
    r = -1;
    if (dec_mode) r = int'(row_out);
    else begin
      for (int i = 0; i < 4; i++)
        if ($countones(~row_out) == 1 && !row_out[i]) r = i;
    end
    col_n = (r < 0) ? 8'hFF : ~keys[r*8 +: 8];
  end

  always @(negedge clk) if (key_irq) irq_seen++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 190000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cnt_keys(logic [127:0] k);
    int c = 0;
    for (int i = 0; i < 128; i++) if (k[i] && c < 4) c++;
    return c;
  endfunction

  function automatic int nth_key(logic [127:0] k, int n);
    int c = 0;
    for (int i = 0; i < 128; i++)
      if (k[i]) begin
        if (c == n) return i;
        c++;
      end
    return 0;
  endfunction

  task automatic settle();
    int fl = (dec_mode ? 16 : 4) * DWELL * PRE;
    repeat ((int'(deb_frames) + 3) * fl + 10) @(negedge clk);
  endtask

  // apply a key set, wait for acceptance, check report, irq and chord
  task automatic apply(input logic [127:0] k, input string tag);
    int c, exp_irq, exp_rst;
    keys = k;
    irq_seen = 0;
    settle();
    c = cnt_keys(k);
    exp_irq = 0;
    if (c <= 3) begin
      exp_irq = ((c == 1 || c == 2) && c != rep_count) ? 1 : 0;
      rep_count  = c;
      rep_first  = nth_key(k, 0);
      rep_second = nth_key(k, 1);
    end
    exp_rst = (chord_en && c == 3 && k[chord_a] && k[chord_b] && k[chord_c]) ? 0 : 1;
    chk(int'(key_count) == rep_count, (c > 3) ? "R8" : "R5", {tag, " count"}, key_count, rep_count);
    chk(int'(key_first) == rep_first, (c > 3) ? "R8" : "R3", {tag, " first"}, key_first, rep_first);
    chk(int'(key_second) == rep_second, "R5", {tag, " second"}, key_second, rep_second);
    chk(irq_seen == exp_irq, "R6", {tag, " irq"}, irq_seen, exp_irq);
    chk(int'(rst_out_n) == exp_rst, (c > 3) ? "R8" : "R7", {tag, " reset out"}, rst_out_n, exp_rst);
  endtask

  logic [127:0] k;
  initial begin
    void'($urandom(32'h5EED_0042));
    arst_n = 1'b0; scan_en = 1'b1; dec_mode = 1'b1; chord_en = 1'b1; sleep_req = 1'b0;
    row_dwell = 4'(DWELL); deb_frames = 4'd3; keys = '0;
    chord_a = 7'd10; chord_b = 7'd45; chord_c = 7'd100;
    repeat (5) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk(key_count == 0 && key_first == 0 && key_second == 0, "R10", "report after reset", key_count, 0);
    chk(key_irq == 0 && rst_out_n == 1 && wake_req == 0, "R10", "flags after reset",
        {key_irq, rst_out_n, wake_req}, 3'b010);

    // R1 encoded rows visit all sixteen codes
    begin
      logic [15:0] seen = '0;
      repeat (16 * DWELL * PRE + 4) begin @(negedge clk); seen[row_out] = 1'b1; end
      chk(seen == 16'hFFFF, "R1", "encoded rows visited", seen, 16'hFFFF);
    end

    // directed cases
    k = '0; k[9*8+5] = 1'b1; apply(k, "single");
    k[2*8+7] = 1'b1; apply(k, "two keys");
    k = '0; k[chord_a] = 1; k[chord_b] = 1; k[chord_c] = 1; apply(k, "chord");
    k[3] = 1'b1; apply(k, "four keys");
    k = '0; k[1] = 1; k[50] = 1; k[127] = 1; apply(k, "three other");
    apply('0, "release");

    // R4 a press lasting one frame is filtered with four-frame debounce
    deb_frames = 4'd4; irq_seen = 0;
    keys = '0; keys[77] = 1'b1;
    repeat (16 * DWELL * PRE) @(negedge clk);
    keys = '0;
    settle();
    chk(key_count == 0, "R4", "glitch count", key_count, 0);
    chk(irq_seen == 0, "R4", "glitch irq", irq_seen, 0);
    deb_frames = 4'd3;

    // R9 wake-up while sleeping
    sleep_req = 1'b1;
    k = '0; k[66] = 1'b1; apply(k, "sleep press");
    chk(wake_req == 1, "R9", "wake with key", wake_req, 1);
    apply('0, "sleep release");
    chk(wake_req == 0, "R9", "wake without key", wake_req, 0);
    sleep_req = 1'b0;
    k = '0; k[66] = 1'b1; apply(k, "awake press");
    chk(wake_req == 0, "R9", "no wake when awake", wake_req, 0);
    apply('0, "awake release");

    // random key sets, encoded rows
    for (int it = 0; it < 24; it++) begin
      int n = $urandom_range(0, 5);
      k = '0;
      if ($urandom_range(0, 3) == 0) begin
        k[chord_a] = 1; k[chord_b] = 1; k[chord_c] = 1;
      end else
        for (int j = 0; j < n; j++) k[$urandom_range(0, 127)] = 1'b1;
      apply(k, "random");
    end
    apply('0, "random release");

    // R2 direct rows: one low line, all four used, rows 0..3 reported
    dec_mode = 1'b0;
    begin
      logic [3:0] seen = '0;
      int bad = 0;
      repeat (4 * DWELL * PRE + 4) begin
        @(negedge clk);
        if ($countones(~row_out) != 1) bad++;
        seen = seen | ~row_out;
      end
      chk(bad == 0 && seen == 4'hF, "R2", "direct row lines", {bad, seen}, 4'hF);
    end
    k = '0; k[2*8+6] = 1'b1; apply(k, "direct single");
    k[0*8+1] = 1'b1; apply(k, "direct two");
    apply('0, "direct release");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule